// File: doc/BRIEF.md
# Shift and Rotate Unit With Flags

This block performs one shift or rotate on an 8-bit or 16-bit operand. It covers logical shifts in both directions, the sign-preserving right shift, plain rotates, and rotates that pass through the carry flag. It returns the result together with carry, overflow, sign, zero, parity and auxiliary-carry values. It also returns an update mask that tells the surrounding datapath which flags it should overwrite. Flag storage and instruction decode belong to the caller.

Each operation is launched with a one-cycle `start` pulse. The rotate count is either the constant one or the value on the count input. A barrel datapath computes the answer in the same cycle, and a register stage presents it with `done` on the next cycle. The outputs then hold until the next `start`. The unit keeps one datapath lane for each operand width. In 8-bit mode the narrow lane is used, the upper operand byte is ignored and the upper result byte reads zero.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 shifts left and fills with zeros. CF is the last bit shifted out, which is operand bit N-count and is 0 when the count exceeds the width N.
- R2: Operation code 1 shifts right and fills with zeros. CF is the last bit shifted out.
- R3: Operation code 2 shifts right and fills with copies of the original top bit. CF is the last bit shifted out, and the top bit of the result equals the top bit of the operand.
- R4: Operation codes 3 (rotate left) and 4 (rotate right) rotate by the count modulo N. CF is the bit that wrapped last: result bit 0 for a left rotate and result bit N-1 for a right rotate.
- R5: Operation codes 5 (left) and 6 (right) rotate the (N+1)-bit ring formed by the incoming CF above the operand, by the count modulo N+1. CF is the ring's top bit afterwards.
- R6: OF depends on the operation. For any shift it is the XOR of the operand's top bit and the result's top bit. For a left rotate it is the result's top bit XOR the new CF. For a right rotate it is the XOR of the result's two top bits. The same rules apply to every nonzero count.
- R7: For a shift with a nonzero count, SF is the result's top bit and ZF is set when the result is zero. PF is set when the low result byte holds an even number of ones, and AF is 0. The update mask is 6'h3F, with mask bit 0 = CF, 1 = PF, 2 = AF, 3 = ZF, 4 = SF and 5 = OF. The flag outputs use the same bit order.
- R8: For a rotate with a nonzero count, the update mask is 6'h21 (CF and OF only), and the SF, ZF, PF and AF outputs read 0.
- R9: With an effective count of zero, or with operation code 7, the result equals the width-masked operand, CF equals the incoming CF, the other flag outputs are 0 and the mask is 0.
- R10: When `count_one_i` is 1 the count is 1 and `count_i` is ignored. Otherwise the count is `count_i`.
- R11: When `half_i` is 1 the unit works on operand bits 7:0, ignores bits 15:8, returns zero in result bits 15:8, and takes SF from bit 7.
- R12: `done_o` is 1 in exactly the cycle after a `start_i` cycle. While `start_i` is low, all outputs hold their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launches one operation using the inputs of this cycle |
| op_i | input | 3 | Operation code (0 to 7) |
| half_i | input | 1 | 1 selects 8-bit operand width |
| count_one_i | input | 1 | 1 forces a count of one |
| count_i | input | CNT_W | Count value from the count register |
| operand_i | input | W | Operand |
| cf_i | input | 1 | Incoming carry flag |
| done_o | output | 1 | Result valid, one cycle after start |
| result_o | output | W | Shifted or rotated result |
| cf_o | output | 1 | Carry flag value |
| of_o | output | 1 | Overflow flag value |
| sf_o | output | 1 | Sign flag value |
| zf_o | output | 1 | Zero flag value |
| af_o | output | 1 | Auxiliary-carry flag value |
| pf_o | output | 1 | Parity flag value |
| upd_mask_o | output | 6 | Flags the caller should overwrite |

## Verification
The assertions check the following on every cycle:
- the one-cycle start-to-done timing and that outputs hold between operations;
- the pass-through on a zero count;
- the CF/OF-only mask and the cleared SF, ZF and PF outputs after rotates;
- the cleared upper byte in narrow mode;
- sign retention after an arithmetic right shift;
- the forced count of one.

The bench scenarios are needed for the rest:
- exact result and carry values, compared against a reference that steps one bit at a time;
- the modulo behaviour of rotates, including counts that are whole multiples of N or N+1;
- counts larger than the width;
- the overflow rules on multi-bit counts;
- parity of the low byte.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } shrot_op_e;

  // Bit positions shared by the flag vector and the update mask.
  localparam int FB_CF = 0;
  localparam int FB_PF = 1;
  localparam int FB_AF = 2;
  localparam int FB_ZF = 3;
  localparam int FB_SF = 4;
  localparam int FB_OF = 5;
  localparam int FLAG_N = 6;

  function automatic logic op_is_shift(shrot_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction

  function automatic logic op_is_rotate(shrot_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

endpackage

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int N     = 16,
  parameter int CNT_W = 5
) (
  input  shrot_op_e        op_i,
  input  logic [N-1:0]     a_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cf_i,
  output logic [N-1:0]     res_o,
  output logic             cf_o,
  output logic             of_o
);

  localparam int          CNT_MAX = (1 << CNT_W) - 1;
  localparam int          WIDE    = N + CNT_MAX + 2;
  localparam int          RING    = N + 1;
  localparam int unsigned N_U     = N;
  localparam int unsigned RING_U  = RING;

  // Shift paths: one wide vector for each direction, with room for every count.
  logic [WIDE-1:0] shl_v;
  logic [WIDE-1:0] shr_v;
  logic [WIDE-1:0] sar_v;

  assign shl_v = WIDE'(a_i) << cnt_i;
  assign shr_v = {{(WIDE-N-1){1'b0}}, a_i, 1'b0} >> cnt_i;
  assign sar_v = {{(WIDE-N-1){a_i[N-1]}}, a_i, 1'b0} >> cnt_i;

  // Plain rotate through a doubled operand.
  int unsigned     rot_amt;
  logic [2*N-1:0]  rot_dbl;
  logic [2*N-1:0]  rol_v;
  logic [2*N-1:0]  ror_v;

  assign rot_amt = 32'(cnt_i) % N_U;
  assign rot_dbl = {a_i, a_i};
  assign rol_v   = rot_dbl << rot_amt;
  assign ror_v   = rot_dbl >> rot_amt;

  // Rotate through carry: ring of N+1 bits, carry on top.
  int unsigned       rc_amt;
  logic [RING-1:0]   ring;
  logic [2*RING-1:0] rc_dbl;
  logic [2*RING-1:0] rcl_v;
  logic [2*RING-1:0] rcr_v;

  assign rc_amt = 32'(cnt_i) % RING_U;
  assign ring   = {cf_i, a_i};
  assign rc_dbl = {ring, ring};
  assign rcl_v  = rc_dbl << rc_amt;
  assign rcr_v  = rc_dbl >> rc_amt;

  always_comb begin
    res_o = a_i;
    cf_o  = cf_i;
    of_o  = 1'b0;
    unique case (op_i)
      OP_SHL: begin
        res_o = shl_v[N-1:0];
        cf_o  = shl_v[N];
        of_o  = a_i[N-1] ^ shl_v[N-1];
      end
      OP_SHR: begin
        res_o = shr_v[N:1];
        cf_o  = shr_v[0];
        of_o  = a_i[N-1] ^ shr_v[N];
      end
      OP_SAR: begin
        res_o = sar_v[N:1];
        cf_o  = sar_v[0];
        of_o  = a_i[N-1] ^ sar_v[N];
      end
      OP_ROL: begin
        res_o = rol_v[2*N-1:N];
        cf_o  = rol_v[N];
        of_o  = rol_v[2*N-1] ^ rol_v[N];
      end
      OP_ROR: begin
        res_o = ror_v[N-1:0];
        cf_o  = ror_v[N-1];
        of_o  = ror_v[N-1] ^ ror_v[N-2];
      end
      OP_RCL: begin
        res_o = rcl_v[2*RING-2:RING];
        cf_o  = rcl_v[2*RING-1];
        of_o  = rcl_v[2*RING-2] ^ rcl_v[2*RING-1];
      end
      OP_RCR: begin
        res_o = rcr_v[N-1:0];
        cf_o  = rcr_v[N];
        of_o  = rcr_v[N-1] ^ rcr_v[N-2];
      end
      default: begin
        res_o = a_i;
        cf_o  = cf_i;
        of_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      res_i,
  input  logic              half_i,
  input  logic              active_i,
  input  logic              shift_i,
  input  logic              cf_raw_i,
  input  logic              of_raw_i,
  input  logic              cf_in_i,
  output logic [FLAG_N-1:0] flag_o,
  output logic [FLAG_N-1:0] mask_o
);

  localparam int HW = W / 2;

  logic sign_bit;
  logic zero_bit;
  logic par_bit;

  assign sign_bit = half_i ? res_i[HW-1] : res_i[W-1];
  assign zero_bit = (res_i == '0);
  assign par_bit  = ~^res_i[7:0];

  always_comb begin
    flag_o        = '0;
    mask_o        = '0;
    flag_o[FB_CF] = cf_in_i;
    if (active_i) begin
      flag_o[FB_CF] = cf_raw_i;
      flag_o[FB_OF] = of_raw_i;
      mask_o[FB_CF] = 1'b1;
      mask_o[FB_OF] = 1'b1;
      if (shift_i) begin
        flag_o[FB_SF] = sign_bit;
        flag_o[FB_ZF] = zero_bit;
        flag_o[FB_PF] = par_bit;
        flag_o[FB_AF] = 1'b0;
        mask_o[FB_SF] = 1'b1;
        mask_o[FB_ZF] = 1'b1;
        mask_o[FB_PF] = 1'b1;
        mask_o[FB_AF] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic             half_i,
  input  logic             count_one_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [W-1:0]     operand_i,
  input  logic             cf_i,
  output logic             done_o,
  output logic [W-1:0]     result_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             af_o,
  output logic             pf_o,
  output logic [5:0]       upd_mask_o
);

  localparam int HW     = W / 2;
  localparam int LANE_N = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // Decode of operation and count.
  shrot_op_e        op;
  logic [CNT_W-1:0] cnt_eff;
  logic             active;
  logic             is_shift;

  assign op       = shrot_op_e'(op_i);
  assign cnt_eff  = count_one_i ? CNT_W'(1) : count_i;
  assign active   = (cnt_eff != '0) && (op != OP_NOP);
  assign is_shift = op_is_shift(op);

  // One datapath lane for each operand width: lane 0 full, lane 1 half.
  logic [W-1:0] lane_res [LANE_N];
  logic         lane_cf  [LANE_N];
  logic         lane_of  [LANE_N];

  for (genvar k = 0; k < LANE_N; k++) begin : g_lane
    localparam int LW = W >> k;
    logic [LW-1:0] l_res;
    logic          l_cf;
    logic          l_of;

    shrot_core #(.N(LW), .CNT_W(CNT_W)) u_core (
      .op_i  (op),
      .a_i   (operand_i[LW-1:0]),
      .cnt_i (cnt_eff),
      .cf_i  (cf_i),
      .res_o (l_res),
      .cf_o  (l_cf),
      .of_o  (l_of)
    );

    assign lane_res[k] = W'(l_res);
    assign lane_cf[k]  = l_cf;
    assign lane_of[k]  = l_of;
  end

  logic [W-1:0] sel_res;
  logic         sel_cf;
  logic         sel_of;

  assign sel_res = half_i ? lane_res[1] : lane_res[0];
  assign sel_cf  = half_i ? lane_cf[1]  : lane_cf[0];
  assign sel_of  = half_i ? lane_of[1]  : lane_of[0];

  logic [FLAG_N-1:0] flag_c;
  logic [FLAG_N-1:0] mask_c;

  shrot_flags #(.W(W)) u_flags (
    .res_i    (sel_res),
    .half_i   (half_i),
    .active_i (active),
    .shift_i  (is_shift),
    .cf_raw_i (sel_cf),
    .of_raw_i (sel_of),
    .cf_in_i  (cf_i),
    .flag_o   (flag_c),
    .mask_o   (mask_c)
  );

  // Output stage: next-state logic, then registers.
  logic [W-1:0]      res_q,  res_d;
  logic [FLAG_N-1:0] flg_q,  flg_d;
  logic [FLAG_N-1:0] msk_q,  msk_d;
  logic              done_q, done_d;

  always_comb begin
    res_d  = res_q;
    flg_d  = flg_q;
    msk_d  = msk_q;
    done_d = start_i;
    if (start_i) begin
      res_d = sel_res;
      flg_d = flag_c;
      msk_d = mask_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      msk_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      msk_q  <= msk_d;
      done_q <= done_d;
    end
  end

  assign done_o     = done_q;
  assign result_o   = res_q;
  assign cf_o       = flg_q[FB_CF];
  assign of_o       = flg_q[FB_OF];
  assign sf_o       = flg_q[FB_SF];
  assign zf_o       = flg_q[FB_ZF];
  assign af_o       = flg_q[FB_AF];
  assign pf_o       = flg_q[FB_PF];
  assign upd_mask_o = msk_q;

  // Checks on the port behaviour.
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i |=> done_o); // R12
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start_i |=> !done_o); // R12
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start_i |=> ($stable(result_o) && $stable(upd_mask_o) && $stable(cf_o))); // R12
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && cnt_eff == '0) |=> (upd_mask_o == 6'd0 && cf_o == $past(cf_i) &&
      result_o == ($past(half_i) ? {{(W-HW){1'b0}}, $past(operand_i[HW-1:0])}
                                 : $past(operand_i)))); // R9
  AST_ROTATE_MASK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && cnt_eff != '0 && op_i >= 3'd3 && op_i <= 3'd6)
      |=> (upd_mask_o == 6'h21 && !sf_o && !zf_o && !pf_o && !af_o)); // R8
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && half_i) |=> (result_o[W-1:HW] == '0)); // R11
  AST_SAR_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && !half_i && op_i == 3'd2 && cnt_eff != '0)
      |=> (result_o[W-1] == $past(operand_i[W-1]) && !of_o)); // R3
  AST_FORCED_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && count_one_i && !half_i && op_i == 3'd0)
      |=> (cf_o == $past(operand_i[W-1]) && result_o[0] == 1'b0)); // R10

endmodule

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic        half;
  logic        cone;
  logic [4:0]  cnt;
  logic [15:0] opnd;
  logic        cfi;
  logic        done_o;
  logic [15:0] result_o;
  logic        cf_o, of_o, sf_o, zf_o, af_o, pf_o;
  logic [5:0]  upd_mask_o;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  shrot_unit #(.W(16), .CNT_W(5)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (op),
    .half_i      (half),
    .count_one_i (cone),
    .count_i     (cnt),
    .operand_i   (opnd),
    .cf_i        (cfi),
    .done_o      (done_o),
    .result_o    (result_o),
    .cf_o        (cf_o),
    .of_o        (of_o),
    .sf_o        (sf_o),
    .zf_o        (zf_o),
    .af_o        (af_o),
    .pf_o        (pf_o),
    .upd_mask_o  (upd_mask_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Stimulus: {op[25:23], half[22], count[21:17], cf[16], operand[15:0]}
  localparam logic [25:0] VECS [16] = '{
    {3'd0, 1'b0, 5'd3,  1'b0, 16'h1234},
    {3'd1, 1'b0, 5'd4,  1'b1, 16'hF0F1},
    {3'd2, 1'b0, 5'd5,  1'b0, 16'h8F00},
    {3'd3, 1'b0, 5'd7,  1'b0, 16'hA5C3},
    {3'd4, 1'b0, 5'd3,  1'b1, 16'h1001},
    {3'd5, 1'b0, 5'd12, 1'b1, 16'h7E01},
    {3'd6, 1'b0, 5'd17, 1'b0, 16'h8001},
    {3'd0, 1'b1, 5'd2,  1'b0, 16'h00C3},
    {3'd1, 1'b1, 5'd9,  1'b0, 16'h00FF},
    {3'd2, 1'b1, 5'd2,  1'b1, 16'h0090},
    {3'd3, 1'b1, 5'd10, 1'b0, 16'h0081},
    {3'd4, 1'b1, 5'd7,  1'b0, 16'h0042},
    {3'd5, 1'b1, 5'd4,  1'b1, 16'h00F0},
    {3'd6, 1'b1, 5'd8,  1'b1, 16'h0055},
    {3'd2, 1'b0, 5'd31, 1'b0, 16'h8000},
    {3'd5, 1'b1, 5'd18, 1'b0, 16'h0033}
  };

  // Bundle layout: {result16, cf, of, sf, zf, af, pf, mask6}
  function automatic logic [27:0] pk(logic [15:0] r, logic c, logic o, logic s,
                                     logic z, logic a, logic p, logic [5:0] m);
    return {r, c, o, s, z, a, p, m};
  endfunction

  function automatic logic [27:0] observed();
    return pk(result_o, cf_o, of_o, sf_o, zf_o, af_o, pf_o, upd_mask_o);
  endfunction

  // Reference that applies the operation one bit position per step.
  function automatic logic [27:0] model(logic [2:0] o, logic h, logic [4:0] c,
                                        logic ci, logic [15:0] a);
    int          n;
    logic [15:0] v;
    logic [15:0] a0;
    logic        cy;
    logic        t;
    logic        ov;
    n  = h ? 8 : 16;
    a0 = h ? {8'h00, a[7:0]} : a;
    v  = a0;
    cy = ci;
    if (o == 3'd7 || c == 5'd0) return pk(a0, ci, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00);
    for (int i = 0; i < int'(c); i++) begin
      case (o)
        3'd0: begin cy = v[n-1]; v = v << 1; end
        3'd1: begin cy = v[0]; v = v >> 1; end
        3'd2: begin cy = v[0]; t = v[n-1]; v = v >> 1; v[n-1] = t; end
        3'd3: begin cy = v[n-1]; v = (v << 1) | {15'd0, cy}; end
        3'd4: begin cy = v[0]; v = v >> 1; v[n-1] = cy; end
        3'd5: begin t = v[n-1]; v = (v << 1) | {15'd0, cy}; cy = t; end
        default: begin t = v[0]; v = v >> 1; v[n-1] = cy; cy = t; end
      endcase
      if (h) v[15:8] = 8'h00;
    end
    if (o <= 3'd2) begin
      ov = a0[n-1] ^ v[n-1];
      return pk(v, cy, ov, v[n-1], (v == 16'h0), 1'b0, ~^v[7:0], 6'h3F);
    end
    if (o == 3'd3 || o == 3'd5) ov = v[n-1] ^ cy;
    else                        ov = v[n-1] ^ v[n-2];
    return pk(v, cy, ov, 1'b0, 1'b0, 1'b0, 1'b0, 6'h21);
  endfunction

  function automatic string tag(logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [27:0] got, logic [27:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one operation, then sample after the capturing edge.
  task automatic run(logic [2:0] o, logic h, logic c1, logic [4:0] c,
                     logic ci, logic [15:0] a);
    @(negedge clk);
    op = o; half = h; cone = c1; cnt = c; cfi = ci; opnd = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "done after start", {27'd0, done_o}, 28'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [27:0] held;
    rst_n = 1'b0; start = 1'b0; op = 3'd0; half = 1'b0; cone = 1'b0;
    cnt = 5'd0; cfi = 1'b0; opnd = 16'h0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "reset outputs", {observed()[27:0]}, 28'd0);
    chk("R12", "reset done", {27'd0, done_o}, 28'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk against the stepping reference (R1-R5 by op, R6 and R7 in every bundle)
    for (int i = 0; i < 16; i++) begin
      run(VECS[i][25:23], VECS[i][22], 1'b0, VECS[i][21:17], VECS[i][16], VECS[i][15:0]);
      chk(tag(VECS[i][25:23]), $sformatf("vector %0d R6 R7", i), observed(),
          model(VECS[i][25:23], VECS[i][22], VECS[i][21:17], VECS[i][16], VECS[i][15:0]));
    end

    // R10: forced count one overrides count_i = 5; R6 OF from top bit change
    run(3'd0, 1'b0, 1'b1, 5'd5, 1'b0, 16'h8001);
    chk("R10", "count one SHL", observed(), pk(16'h0002, 1, 1, 0, 0, 0, 0, 6'h3F));
    run(3'd1, 1'b0, 1'b1, 5'd5, 1'b0, 16'h0003);
    chk("R10", "count one SHR", observed(), pk(16'h0001, 1, 0, 0, 0, 0, 0, 6'h3F));

    // R3 and R11: narrow arithmetic shift, R7 parity of 0xF0
    run(3'd2, 1'b1, 1'b0, 5'd3, 1'b0, 16'h0081);
    chk("R3", "SAR 8-bit by 3", observed(), pk(16'h00F0, 0, 0, 1, 0, 0, 1, 6'h3F));

    // R11: upper byte ignored
    run(3'd0, 1'b1, 1'b0, 5'd1, 1'b0, 16'hAB01);
    chk("R11", "upper byte ignored", observed(), pk(16'h0002, 0, 0, 0, 0, 0, 0, 6'h3F));

    // R1: count larger than width; R7 zero and parity on empty result
    run(3'd0, 1'b0, 1'b0, 5'd20, 1'b0, 16'h8421);
    chk("R1", "SHL by 20", observed(), pk(16'h0000, 0, 1, 0, 1, 0, 1, 6'h3F));

    // R2: last bit out
    run(3'd1, 1'b0, 1'b0, 5'd2, 1'b0, 16'h0003);
    chk("R2", "SHR by 2", observed(), pk(16'h0000, 1, 0, 0, 1, 0, 1, 6'h3F));

    // R5: narrow ring of 9 returns to start
    run(3'd6, 1'b1, 1'b0, 5'd9, 1'b0, 16'h0001);
    chk("R5", "RCR 8-bit by 9", observed(), pk(16'h0001, 0, 0, 0, 0, 0, 0, 6'h21));

    // R8: rotate with zero result keeps ZF and PF at 0 and mask at CF/OF
    run(3'd5, 1'b0, 1'b0, 5'd1, 1'b0, 16'h8000);
    chk("R8", "RCL zero result", observed(), pk(16'h0000, 1, 1, 0, 0, 0, 0, 6'h21));

    // R4: full-width rotate count, and right rotate OF
    run(3'd3, 1'b0, 1'b0, 5'd16, 1'b1, 16'h1234);
    chk("R4", "ROL by 16", observed(), pk(16'h1234, 0, 0, 0, 0, 0, 0, 6'h21));
    run(3'd4, 1'b1, 1'b0, 5'd1, 1'b0, 16'h0001);
    chk("R4", "ROR 8-bit by 1", observed(), pk(16'h0080, 1, 1, 0, 0, 0, 0, 6'h21));

    // R9: zero count and code 7 leave operand and carry
    run(3'd0, 1'b0, 1'b0, 5'd0, 1'b1, 16'hBEEF);
    chk("R9", "zero count", observed(), pk(16'hBEEF, 1, 0, 0, 0, 0, 0, 6'h00));
    run(3'd7, 1'b0, 1'b0, 5'd4, 1'b0, 16'h00FF);
    chk("R9", "code 7", observed(), pk(16'h00FF, 0, 0, 0, 0, 0, 0, 6'h00));

    // R12: outputs hold while idle, done drops
    run(3'd3, 1'b0, 1'b0, 5'd4, 1'b0, 16'h1234);
    held = observed();
    chk("R4", "ROL by 4", held, pk(16'h2341, 1, 1, 0, 0, 0, 0, 6'h21));
    @(negedge clk);
    op = 3'd1; opnd = 16'hFFFF; cnt = 5'd3;
    chk("R12", "done low when idle", {27'd0, done_o}, 28'd0);
    repeat (2) @(negedge clk);
    chk("R12", "outputs held", observed(), held);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule